// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block generates two independent pulse-width modulated outputs. Each channel's base rate comes from an input clock divider. A small 32-bit register bus reaches three words. The shared control word holds a 10-bit field per channel: divider code, enable, active level, clock gate, one-shot mode, pulse request and a divider override. Each channel also has one period/duty word. The control word also shows a read-only ready flag per channel.

A write to a period/duty word goes into a shadow copy and raises that channel's ready flag. A running channel takes up the new value only when its current period ends. A stopped channel takes it up on the next clock edge. While the flag is set, any further write to that word is dropped. Software therefore polls the flag before it writes again.

Each channel is built around a four-state machine:
- `CH_OFF` is entered when enable or clock gate is clear.
- `CH_ARMED` is the idle state in one-shot mode.
- `CH_RUN` counts continuously.
- `CH_SHOT` emits one period.

The transitions are:
- OFF goes to RUN, or to ARMED when the mode bit is set, once both enable and gate are set.
- ARMED goes to SHOT when the pulse bit is set, and to RUN when the mode bit is cleared.
- RUN goes to ARMED when the mode bit is set.
- SHOT goes back to ARMED at its period end and clears the pulse bit. It goes to RUN when the mode bit is cleared.
- Every state falls to OFF when enable or gate drops.

Top module: `pwm_dual_presc`

## Requirements
- R1: The control word is at byte offset 0x0. Channel n's period/duty word is at 0x4+4n. Channel n's control field sits at bits [15n+9:15n]: [3:0] divider code, 4 enable, 5 active level, 6 clock gate, 7 one-shot mode, 8 pulse request, 9 divider override. All other control bits read 0. Addresses that are not word-aligned read 0 and ignore writes.
- R2: Bit 28+n of the control word reads 1 from the edge that accepts a write to channel n's period/duty word. While the channel is stopped, it reads 0 again one edge later.
- R3: A write to a period/duty word while that channel's ready bit is 1 is discarded, and the word reads back its earlier value.
- R4: Period/duty word bits [31:16] hold P-1 and bits [15:0] hold D. Every period spans P counts, and the output is active for the first min(D,P) counts.
- R5: D = 0 gives a constant inactive output. D >= P gives a constant active output.
- R6: Divider codes 0, 1, 2, 3, 4 make one count last 2, 3, 4, 6, 8 × DIV_BASE input clocks. At the default DIV_BASE of 60 that is 120 to 480.
- R7: Divider codes 8, 9, 10, 11, 12 make one count last 200, 400, 600, 800, 1200 × DIV_BASE input clocks.
- R8: Code 15, or a set override bit whatever the code, makes one count last one input clock.
- R9: Codes 5, 6, 7, 13 and 14 without the override stop the counter. A pending period/duty value is then never taken up by a running channel, and its ready bit stays 1.
- R10: With active level 1 the output is high while active. With active level 0 every level is inverted.
- R11: While enable or clock gate is 0, the output holds the inactive level, which is the inverse of the active-level bit. After reset all control bits are 0, so both outputs are high.
- R12: A running channel takes up a pending value at the end of its current period. The ready bit clears at that edge, and the new period and duty then govern the output.
- R13: With mode 1 the output stays inactive until the pulse bit is set. It then emits exactly one period, and the hardware clears the pulse bit.
- R14: With mode 0 the channel repeats its period for as long as it is enabled and gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock feeding both dividers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 2*CNT_W | Write data |
| bus_rdata | output | 2*CNT_W | Read data for bus_addr, combinational |
| pwm_out | output | NCH | Modulated outputs, one per channel |

## Verification
The bench instantiates the block with DIV_BASE = 1 and all other parameters at their defaults. The dividers then shrink to 2 through 1200 input clocks, so a single short run can sweep every valid code, both override paths and both polarities over several period and duty pairs. Whole-period windows make the expected active-cycle count a plain product of duty, period and divider, whatever the phase. The slowest code stretches one period to thousands of clocks, which keeps a pending update visibly outstanding. That window is used to show that a second write is dropped and that the ready bit clears at the period end.

// File: rtl/pwm_dual_presc_pkg.sv
package pwm_dual_presc_pkg;

    // Per-channel control field, bit 9 down to bit 0.
    typedef struct packed {
        logic       bypass;
        logic       pulse;
        logic       mode;
        logic       gate;
        logic       act;
        logic       en;
        logic [3:0] code;
    } chan_cfg_t;

    localparam int unsigned CFG_W    = $bits(chan_cfg_t);
    localparam int unsigned MAX_MULT = 1200;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2,
        CH_SHOT  = 2'd3
    } chan_state_t;

    // Divider multiple for a code; 0 marks codes with no divider (15 handled apart).
    function automatic int unsigned div_mult(input logic [3:0] code);
        case (code)
            4'd0:    return 2;
            4'd1:    return 3;
            4'd2:    return 4;
            4'd3:    return 6;
            4'd4:    return 8;
            4'd8:    return 200;
            4'd9:    return 400;
            4'd10:   return 600;
            4'd11:   return 800;
            4'd12:   return 1200;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_presc_div.sv
module pwm_presc_div
    import pwm_dual_presc_pkg::*;
#(
    parameter int unsigned DIV_BASE = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    input  logic       bypass,
    output logic       tick
);
    localparam int unsigned MAX_DIV = DIV_BASE * MAX_MULT;
    localparam int unsigned PRE_W   = $clog2(MAX_DIV + 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] div_m1;
    logic             div_ok;
    int unsigned      mult;

    always_comb begin
        mult = div_mult(code);
        if (bypass || code == 4'd15) begin
            div_ok = 1'b1;
            div_m1 = '0;
        end else if (mult != 0) begin
            div_ok = 1'b1;
            div_m1 = PRE_W'(DIV_BASE * mult - 1);
        end else begin
            div_ok = 1'b0;
            div_m1 = '0;
        end
    end

    assign tick = run && div_ok && (pre_q >= div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || !div_ok || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
    import pwm_dual_presc_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned DIV_BASE = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  chan_cfg_t          cfg,
    input  logic               pd_wr,
    input  logic [2*CNT_W-1:0] pd_wdata,
    output logic [2*CNT_W-1:0] pd_shadow,
    output logic               ready,
    output logic               shot_done,
    output logic               pwm_o
);
    chan_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, prd_q, dty_q, sh_prd_q, sh_dty_q;
    logic             pend_q, tick, counting, run_req, period_end;

    assign run_req = cfg.en && cfg.gate;

    pwm_presc_div #(.DIV_BASE(DIV_BASE)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (counting),
        .code   (cfg.code),
        .bypass (cfg.bypass),
        .tick   (tick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:   if (run_req) state_d = cfg.mode ? CH_ARMED : CH_RUN;
            CH_ARMED: if (!run_req)       state_d = CH_OFF;
                      else if (!cfg.mode) state_d = CH_RUN;
                      else if (cfg.pulse) state_d = CH_SHOT;
            CH_RUN:   if (!run_req)       state_d = CH_OFF;
                      else if (cfg.mode)  state_d = CH_ARMED;
            CH_SHOT:  if (!run_req)       state_d = CH_OFF;
                      else if (!cfg.mode) state_d = CH_RUN;
                      else if (period_end) state_d = CH_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        counting   = (state_q == CH_RUN) || (state_q == CH_SHOT);
        period_end = tick && (cnt_q == prd_q);
        shot_done  = (state_q == CH_SHOT) && period_end && run_req && cfg.mode;
        ready      = pend_q;
        pd_shadow  = {sh_prd_q, sh_dty_q};
        if (counting && (cnt_q < dty_q)) pwm_o = cfg.act;
        else                             pwm_o = !cfg.act;
    end

    // Counter, shadow and active period/duty
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            prd_q    <= '0;
            dty_q    <= '0;
            sh_prd_q <= '0;
            sh_dty_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (!counting)       cnt_q <= '0;
            else if (period_end) cnt_q <= '0;
            else if (tick)       cnt_q <= cnt_q + CNT_W'(1);

            if (pend_q && (!counting || period_end)) begin
                prd_q  <= sh_prd_q;
                dty_q  <= sh_dty_q;
                pend_q <= 1'b0;
            end else if (pd_wr && !pend_q) begin
                sh_prd_q <= pd_wdata[2*CNT_W-1:CNT_W];
                sh_dty_q <= pd_wdata[CNT_W-1:0];
                pend_q   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_dual_presc.sv
module pwm_dual_presc
    import pwm_dual_presc_pkg::*;
#(
    parameter int unsigned NCH          = 2,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned DIV_BASE     = 60,
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned FIELD_STRIDE = 15,
    parameter int unsigned RDY_BASE     = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [2*CNT_W-1:0] bus_wdata,
    output logic [2*CNT_W-1:0] bus_rdata,
    output logic [NCH-1:0]     pwm_out
);
    localparam int unsigned BUS_W = 2 * CNT_W;
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]            widx;
    logic                        aligned, bus_wr, ctrl_wr;
    chan_cfg_t [NCH-1:0]         cfg_q;
    logic [NCH-1:0][BUS_W-1:0]   pd_shadow;
    logic [NCH-1:0]              pd_wr, ready, shot_done;
    logic [NCH-1:0]              cfg_en, cfg_gate, cfg_act, cfg_mode, cfg_pulse, cfg_bypass;
    logic [4*NCH-1:0]            cfg_code;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign bus_wr  = bus_en && bus_we && aligned;
    assign ctrl_wr = bus_wr && (widx == '0);

    // Control register: software write wins over the hardware pulse clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (ctrl_wr)           cfg_q[n] <= bus_wdata[n*FIELD_STRIDE +: CFG_W];
                else if (shot_done[n]) cfg_q[n].pulse <= 1'b0;
            end
        end
    end

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            assign pd_wr[n]          = bus_wr && (widx == IDX_W'(n + 1));
            assign cfg_en[n]         = cfg_q[n].en;
            assign cfg_gate[n]       = cfg_q[n].gate;
            assign cfg_act[n]        = cfg_q[n].act;
            assign cfg_mode[n]       = cfg_q[n].mode;
            assign cfg_pulse[n]      = cfg_q[n].pulse;
            assign cfg_bypass[n]     = cfg_q[n].bypass;
            assign cfg_code[4*n +: 4] = cfg_q[n].code;

            pwm_chan_core #(.CNT_W(CNT_W), .DIV_BASE(DIV_BASE)) u_core (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg       (cfg_q[n]),
                .pd_wr     (pd_wr[n]),
                .pd_wdata  (bus_wdata),
                .pd_shadow (pd_shadow[n]),
                .ready     (ready[n]),
                .shot_done (shot_done[n]),
                .pwm_o     (pwm_out[n])
            );
        end
    endgenerate

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (widx == '0) begin
                for (int n = 0; n < NCH; n++) begin
                    bus_rdata[n*FIELD_STRIDE +: CFG_W] = cfg_q[n];
                    bus_rdata[RDY_BASE + n]            = ready[n];
                end
            end else begin
                for (int n = 0; n < NCH; n++) begin
                    if (widx == IDX_W'(n + 1)) bus_rdata = pd_shadow[n];
                end
            end
        end
    end

endmodule

// File: rtl/pwm_dual_presc_chk.sv
module pwm_dual_presc_chk
    import pwm_dual_presc_pkg::*;
#(
    parameter int unsigned NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic [NCH-1:0]   pd_wr,
    input logic [NCH-1:0]   cfg_en,
    input logic [NCH-1:0]   cfg_gate,
    input logic [NCH-1:0]   cfg_act,
    input logic [NCH-1:0]   cfg_mode,
    input logic [NCH-1:0]   cfg_pulse,
    input logic [NCH-1:0]   cfg_bypass,
    input logic [4*NCH-1:0] cfg_code,
    input logic [NCH-1:0]   ready,
    input logic [NCH-1:0]   pwm_out
);
    logic [NCH-1:0] bad_code, live;

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            bad_code[n] = (cfg_code[4*n +: 4] != 4'd15) && (div_mult(cfg_code[4*n +: 4]) == 0)
                          && !cfg_bypass[n];
            live[n]     = cfg_en[n] && cfg_gate[n];
        end
    end

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_chk
            AST_STOP_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
                (!live[n] && $past(!live[n])) |-> (pwm_out[n] == !cfg_act[n])) // R11
                else $error("stopped channel %0d drives active level", n);

            AST_READY_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ready[n]) |-> $past(pd_wr[n])) // R2
                else $error("ready %0d rose without a write", n);

            AST_BAD_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (ready[n] && live[n] && !cfg_mode[n] && bad_code[n]
                 && $past(live[n] && !cfg_mode[n])) |=> ready[n]) // R9
                else $error("pending update taken with a stopped divider on %0d", n);

            AST_PULSE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(cfg_pulse[n]) && !$past(ctrl_wr)) |-> $past(cfg_mode[n] && live[n])) // R13
                else $error("pulse bit %0d cleared outside a one-shot", n);
        end
    endgenerate

endmodule

bind pwm_dual_presc pwm_dual_presc_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .pd_wr      (pd_wr),
    .cfg_en     (cfg_en),
    .cfg_gate   (cfg_gate),
    .cfg_act    (cfg_act),
    .cfg_mode   (cfg_mode),
    .cfg_pulse  (cfg_pulse),
    .cfg_bypass (cfg_bypass),
    .cfg_code   (cfg_code),
    .ready      (ready),
    .pwm_out    (pwm_out)
);

// File: tb/pwm_dual_presc_tb.sv
`timescale 1ns/1ps
module pwm_dual_presc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int nvec = 0;
    int nerr = 0;
    logic [31:0] ctrl_img = '0;

    always #4 clk = ~clk;

    pwm_dual_presc #(.DIV_BASE(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [9:0] mk(input int code, input bit en, input bit act, input bit gate,
                                      input bit mode, input bit pulse, input bit byp);
        return {byp, pulse, mode, gate, act, en, 4'(code)};
    endfunction

    task automatic set_field(input int ch, input logic [9:0] f);
        ctrl_img[ch*15 +: 10] = f;
        bus_write(4'h0, ctrl_img);
    endtask

    task automatic count_high(input int ch, input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            h += int'(pwm_out[ch]);
        end
    endtask

    function automatic int exp_div(input int code, input bit byp);
        if (byp || code == 15) return 1;
        case (code)
            0: return 2;   1: return 3;   2: return 4;   3: return 6;   4: return 8;
            8: return 200; 9: return 400; 10: return 600; 11: return 800; 12: return 1200;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int code, input bit byp, input bit act, input int p, input int d);
        string s = "R4 R14";
        if (d == 0 || d >= p) s = {s, " R5"};
        if (byp || code == 15) s = {s, " R8"};
        else if (code < 8)     s = {s, " R6"};
        else                   s = {s, " R7"};
        if (!act) s = {s, " R10"};
        return s;
    endfunction

    // Continuous run on channel 0; active cycles counted over k whole periods
    task automatic run_case(input int code, input bit byp, input bit act, input int p, input int d, input int k);
        int m, lo, h, e;
        set_field(0, 10'd0);
        bus_write(4'h4, {16'(p - 1), 16'(d)});
        wait_cyc(2);
        set_field(0, mk(code, 1, act, 1, 0, 0, byp));
        wait_cyc(3);
        m  = exp_div(code, byp);
        lo = (d < p) ? d : p;
        count_high(0, k * p * m, h);
        e = act ? k * lo * m : k * (p - lo) * m;
        check($sformatf("%s code=%0d byp=%0d act=%0d P=%0d D=%0d", tag_of(code, byp, act, p, d),
                        code, byp, act, p, d), h, e);
    endtask

    initial begin
        #(200000 * 8 - 100);
        nvec++; nerr++;
        $display("FAIL watchdog: run incomplete (got timeout, expected completion)");
        report();
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] wv;
        int h;
        int waited;
        int plist[3] = '{1, 3, 5};
        int badc[5]  = '{5, 6, 7, 13, 14};

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // Reset state
        bus_read(4'h0, rd); check("R11 reset ctrl", rd, 0);
        bus_read(4'h4, rd); check("R1 reset pd0", rd, 0);
        check("R11 reset outputs inactive high", pwm_out, 3);

        // R1 control layout readback, reserved and ready bits ignored
        wv = 32'h3AF | (32'h2C3 << 15) | 32'hF3007C00;
        bus_write(4'h0, wv);
        bus_read(4'h0, rd);
        check("R1 ctrl readback", rd, 32'h3AF | (32'h2C3 << 15));
        bus_read(4'h2, rd); check("R1 unaligned read zero", rd, 0);
        bus_write(4'h0, 32'h0);
        ctrl_img = '0;

        // R2 ready on stopped channel
        bus_write(4'h8, 32'h1234_5678);
        bus_read(4'h0, rd); check("R2 ready set after write ch1", rd[29], 1);
        wait_cyc(1);
        bus_read(4'h0, rd); check("R2 ready clears while stopped", rd[29], 0);
        bus_read(4'h8, rd); check("R1 pd1 readback", rd, 32'h1234_5678);

        // Sweeps of small dividers and bypass
        for (int c = 0; c <= 15; c++) begin
            if (!(c <= 4 || c == 15)) continue;
            foreach (plist[i]) begin
                int dl[5];
                dl = '{0, 1, 2, plist[i], plist[i] + 2};
                foreach (dl[j]) begin
                    run_case(c, 0, 1, plist[i], dl[j], 2);
                    run_case(c, 0, 0, plist[i], dl[j], 2);
                end
            end
        end
        run_case(5, 1, 1, 3, 1, 2);
        run_case(3, 1, 1, 3, 3, 2);
        run_case(12, 1, 0, 3, 1, 2);
        // Large dividers
        for (int c = 8; c <= 12; c++) begin
            run_case(c, 0, 1, 2, 0, 1);
            run_case(c, 0, 1, 2, 1, 1);
            run_case(c, 0, 1, 2, 5, 1);
        end
        set_field(0, 10'd0);

        // R11 stopped channel levels
        bus_write(4'h4, {16'd3, 16'd4});
        wait_cyc(2);
        set_field(0, mk(15, 1, 1, 0, 0, 0, 0));
        wait_cyc(2);
        count_high(0, 40, h); check("R11 gate off act=1", h, 0);
        set_field(0, mk(15, 0, 0, 1, 0, 0, 0));
        wait_cyc(2);
        count_high(0, 40, h); check("R11 enable off act=0", h, 40);
        set_field(0, mk(15, 0, 1, 1, 0, 0, 0));
        wait_cyc(2);
        count_high(0, 40, h); check("R11 enable off act=1", h, 0);

        // R13 one-shot
        for (int c = 15; c >= 0; c -= 15) begin
            set_field(0, 10'd0);
            bus_write(4'h4, {16'd3, 16'd2});
            wait_cyc(2);
            set_field(0, mk(c, 1, 1, 1, 1, 0, 0));
            count_high(0, 30, h); check("R13 armed stays inactive", h, 0);
            set_field(0, mk(c, 1, 1, 1, 1, 1, 0));
            count_high(0, 60, h); check($sformatf("R13 one period code=%0d", c), h, 2 * exp_div(c, 0));
            bus_read(4'h0, rd); check("R13 pulse bit cleared", rd[8], 0);
            count_high(0, 40, h); check("R13 no second period", h, 0);
        end
        set_field(0, 10'd0);

        // R3 / R12 blocked write and latch at period end (code 12, 1200 clocks per count)
        bus_write(4'h8, {16'd1, 16'd1});
        wait_cyc(2);
        set_field(1, mk(12, 1, 1, 1, 0, 0, 0));
        wait_cyc(3);
        bus_write(4'h8, {16'd1, 16'd2});
        bus_read(4'h0, rd); check("R2 ready set while running", rd[29], 1);
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_read(4'h8, rd); check("R3 write dropped while pending", rd, {16'd1, 16'd2});
        waited = 0;
        for (int i = 0; i < 3000; i++) begin
            bus_read(4'h0, rd);
            if (!rd[29]) break;
            @(negedge clk);
            waited++;
        end
        check("R12 ready clears at period end", rd[29], 0);
        check("R12 cleared within one period", (waited <= 2410) ? 1 : 0, 1);
        count_high(1, 2400, h); check("R12 new duty governs output", h, 2400);
        bus_read(4'h8, rd); check("R3 value after latch", rd, {16'd1, 16'd2});
        set_field(1, 10'd0);
        wait_cyc(2);

        // R9 invalid codes stop the counter
        foreach (badc[i]) begin
            set_field(1, 10'd0);
            wait_cyc(2);
            set_field(1, mk(badc[i], 1, 1, 1, 0, 0, 0));
            wait_cyc(3);
            bus_write(4'h8, {16'd3, 16'd1});
            wait_cyc(300);
            bus_read(4'h0, rd);
            check($sformatf("R9 ready held code=%0d", badc[i]), rd[29], 1);
        end
        set_field(1, mk(15, 1, 1, 1, 0, 0, 0));
        wait_cyc(10);
        bus_read(4'h0, rd); check("R8 valid code resumes and latches", rd[29], 0);
        set_field(1, 10'd0);

        wait_cyc(5);
        report();
    end
endmodule